// File: doc/BRIEF.md
# Command Packet Address Classifier

This block sits behind the bit-level receiver of a model-railway track command decoder. The receiver hands over the data bytes of one packet as a byte stream: `in_vld` marks a byte and `in_last` marks the final byte, which is the error-check byte. The block classifies the packet by the range of its first byte, takes out the decoder address, and finds where each instruction inside the packet begins. It also checks the packet length, the check byte and that the instructions fill the packet exactly. It does not act on any instruction.

For the two multi-function address classes and for broadcast, the block walks the instruction bytes. It works out each instruction's length from its opening byte and records a bit for every byte position where an instruction starts. Accessory, reserved and idle packets are classified and checked but not walked. One cycle after the last byte, a single-cycle result carries the class, the address, the index of the first instruction byte, the start-position mask, the instruction count and exactly one of a good flag or a bad flag.

Top module: `pkt_classifier`

## Requirements
- R1: After reset, and after a reset that arrives part way through a packet, `res_vld`, `res_good`, `res_bad`, `res_mask` and `res_icnt` are 0, and the next packet is judged without any trace of the interrupted one.
- R2: `res_vld` rises for exactly one cycle, in the cycle after the clock edge that accepts a byte with `in_last` high. While `res_vld` is high exactly one of `res_good`/`res_bad` is 1; otherwise both are 0.
- R3: `res_class` follows the first byte. 0x00 gives 0 (broadcast). 0x01..0x7F gives 1 (short multi-function). 0x80..0xBF gives 2 (accessory). 0xC0..0xE7 gives 3 (long multi-function). 0xE8..0xFE gives 4 (reserved). 0xFF gives 5 (idle).
- R4: A packet of fewer than 3 or more than 6 bytes, counting the check byte, is bad.
- R5: A packet whose last byte differs from the XOR of all earlier bytes is bad.
- R6: For class 1, `res_addr` is the first byte's low 7 bits. For class 0 it is 0. In both cases `res_base` is 1, because instructions start at byte index 1.
- R7: For class 3, `res_addr` is {first byte bits 5..0, second byte} (14 bits) and `res_base` is 2.
- R8: Instruction length is set by the opening byte. 001xxxxx, 0001xxxx and 1111xxxx are 2 bytes. 1110xxxx is 3 bytes. Every other opening byte outside the 110 type is 1 byte. Bit i of `res_mask` is set when byte index i opens an instruction, and `res_icnt` counts the set bits.
- R9: Within type 110xxxxx, the opener 11000000 takes 3 bytes and every other 110 opener takes 2 bytes.
- R10: A walked packet (class 0, 1 or 3) is bad if its last instruction overruns the check byte or if it holds no instruction at all.
- R11: Classes 2, 4 and 5 report `res_mask` = 0, `res_icnt` = 0 and `res_base` = 0. Their good/bad result depends only on length and check byte.
- R12: For class 2, `res_addr` is the first byte's low 6 bits. For classes 4 and 5 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | A packet byte is present |
| in_last | input | 1 | The present byte is the check byte that ends the packet |
| in_data | input | 8 | Packet byte |
| res_vld | output | 1 | Result pulse, one cycle |
| res_class | output | 3 | Address class code (R3) |
| res_addr | output | 14 | Decoded decoder address |
| res_base | output | 3 | Byte index of the first instruction, 0 if none |
| res_mask | output | 6 | Bit per byte index that opens an instruction |
| res_icnt | output | 3 | Number of instructions found |
| res_good | output | 1 | Packet passed all checks |
| res_bad | output | 1 | Packet failed a check |

## Verification
The class register and the pending-byte counter of the walker carry state from one byte to the next. A wrong value in either shows up only at the next `res_vld` pulse, but it shows up there for certain. A wrong remaining count moves the later mask bits and flips the good flag. A stale class gives the wrong base, the wrong address or a wrong mask. Packets of every length up to the limit are therefore used, together with instruction mixes whose boundaries fall at different byte positions, a reset in the middle of a packet, and idle gaps between bytes. A wrong byte counter appears in the length verdict for both the shortest and the longest packets.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;

  typedef enum logic [2:0] {
    CLS_BCAST = 3'd0,
    CLS_SHORT = 3'd1,
    CLS_ACC   = 3'd2,
    CLS_LONG  = 3'd3,
    CLS_RSVD  = 3'd4,
    CLS_IDLE  = 3'd5
  } addr_class_e;

  // Number of data bytes that follow an instruction's opening byte.
  function automatic logic [1:0] op_extra(input logic [7:0] op);
    logic [1:0] r;
    r = 2'd0;
    if (op[7:5] == 3'b001)      r = 2'd1;
    else if (op[7:4] == 4'b0001) r = 2'd1;
    else if (op[7:4] == 4'b1111) r = 2'd1;
    else if (op[7:4] == 4'b1110) r = 2'd2;
    else if (op[7:5] == 3'b110)  r = (op[4:0] == 5'd0) ? 2'd2 : 2'd1;
    return r;
  endfunction

  function automatic logic cls_walked(input addr_class_e c);
    return (c == CLS_BCAST) || (c == CLS_SHORT) || (c == CLS_LONG);
  endfunction

endpackage

// File: rtl/pkt_lead_decode.sv
module pkt_lead_decode
  import pkt_cls_pkg::*;
(
  input  logic [7:0]  lead,
  output addr_class_e cls
);
  always_comb begin
    if (lead == 8'h00)       cls = CLS_BCAST;
    else if (!lead[7])       cls = CLS_SHORT;
    else if (!lead[6])       cls = CLS_ACC;
    else if (lead <= 8'hE7)  cls = CLS_LONG;
    else if (lead != 8'hFF)  cls = CLS_RSVD;
    else                     cls = CLS_IDLE;
  end
endmodule

// File: rtl/pkt_frame_track.sv
module pkt_frame_track
  import pkt_cls_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int IDX_W     = $clog2(MAX_BYTES + 2)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_last,
  input  logic [7:0]       in_data,
  input  addr_class_e      cls_lead,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       xacc,
  output addr_class_e      cls_q,
  output logic [7:0]       lead_q,
  output logic [7:0]       sec_q
);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(MAX_BYTES + 1);

  always_ff @(posedge clk) begin
    if (rst || (in_vld && in_last)) begin
      idx    <= '0;
      xacc   <= '0;
      cls_q  <= CLS_BCAST;
      lead_q <= '0;
      sec_q  <= '0;
    end else if (in_vld) begin
      if (idx != IDX_SAT) idx <= idx + 1'b1;
      xacc <= xacc ^ in_data;
      if (idx == '0) begin
        cls_q  <= cls_lead;
        lead_q <= in_data;
      end
      if (idx == IDX_W'(1)) sec_q <= in_data;
    end
  end
endmodule

// File: rtl/pkt_instr_walker.sv
module pkt_instr_walker
  import pkt_cls_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int IDX_W     = $clog2(MAX_BYTES + 2)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           op,
  output logic                 pend_zero,
  output logic [MAX_BYTES-1:0] mask,
  output logic [IDX_W-1:0]     icnt
);
  logic [1:0] pend;

  assign pend_zero = (pend == 2'd0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend <= '0;
      mask <= '0;
      icnt <= '0;
    end else if (step) begin
      if (pend == 2'd0) begin
        for (int i = 0; i < MAX_BYTES; i++)
          if (idx == IDX_W'(i)) mask[i] <= 1'b1;
        icnt <= icnt + 1'b1;
        pend <= op_extra(op);
      end else begin
        pend <= pend - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_classifier.sv
module pkt_classifier
  import pkt_cls_pkg::*;
#(
  parameter int MIN_BYTES = 3,
  parameter int MAX_BYTES = 6,
  parameter int IDX_W     = $clog2(MAX_BYTES + 2)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 in_last,
  input  logic [7:0]           in_data,
  output logic                 res_vld,
  output logic [2:0]           res_class,
  output logic [13:0]          res_addr,
  output logic [IDX_W-1:0]     res_base,
  output logic [MAX_BYTES-1:0] res_mask,
  output logic [IDX_W-1:0]     res_icnt,
  output logic                 res_good,
  output logic                 res_bad
);
  addr_class_e          cls_lead, cls_q, cls_now;
  logic [IDX_W-1:0]     idx, icnt, base_now;
  logic [7:0]           xacc, lead_q, sec_q, lead_now;
  logic                 pend_zero, walk, step, eop;
  logic                 len_ok, xor_ok, fill_ok, good_now;
  logic [MAX_BYTES-1:0] mask;
  logic [13:0]          addr_now;

  pkt_lead_decode u_lead (.lead(in_data), .cls(cls_lead));

  pkt_frame_track #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_last(in_last), .in_data(in_data),
    .cls_lead(cls_lead), .idx(idx), .xacc(xacc), .cls_q(cls_q),
    .lead_q(lead_q), .sec_q(sec_q)
  );

  assign eop      = in_vld && in_last;
  assign cls_now  = (idx == '0) ? cls_lead : cls_q;
  assign lead_now = (idx == '0) ? in_data : lead_q;
  assign walk     = cls_walked(cls_now);
  assign base_now = !walk ? '0 : (cls_now == CLS_LONG) ? IDX_W'(2) : IDX_W'(1);
  assign step     = in_vld && !in_last && walk && (idx != '0) &&
                    (idx >= base_now) && (idx < IDX_W'(MAX_BYTES));

  pkt_instr_walker #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst(rst), .clr(eop), .step(step), .idx(idx), .op(in_data),
    .pend_zero(pend_zero), .mask(mask), .icnt(icnt)
  );

  always_comb begin
    case (cls_now)
      CLS_SHORT: addr_now = {7'd0, lead_now[6:0]};
      CLS_ACC:   addr_now = {8'd0, lead_now[5:0]};
      CLS_LONG:  addr_now = {lead_now[5:0], sec_q};
      default:   addr_now = '0;
    endcase
  end

  assign len_ok   = (idx >= IDX_W'(MIN_BYTES - 1)) && (idx <= IDX_W'(MAX_BYTES - 1));
  assign xor_ok   = (xacc == in_data);
  assign fill_ok  = !walk || (pend_zero && (icnt != '0));
  assign good_now = len_ok && xor_ok && fill_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_class <= '0;
      res_addr  <= '0;
      res_base  <= '0;
      res_mask  <= '0;
      res_icnt  <= '0;
      res_good  <= 1'b0;
      res_bad   <= 1'b0;
    end else begin
      res_vld  <= eop;
      res_good <= eop && good_now;
      res_bad  <= eop && !good_now;
      if (eop) begin
        res_class <= cls_now;
        res_addr  <= addr_now;
        res_base  <= base_now;
        res_mask  <= mask;
        res_icnt  <= icnt;
      end
    end
  end
endmodule

// File: rtl/pkt_classifier_chk.sv
module pkt_classifier_chk #(
  parameter int MAX_BYTES = 6,
  parameter int IDX_W     = 3
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_vld,
  input logic                 in_last,
  input logic                 res_vld,
  input logic [2:0]           res_class,
  input logic [13:0]          res_addr,
  input logic [IDX_W-1:0]     res_base,
  input logic [MAX_BYTES-1:0] res_mask,
  input logic [IDX_W-1:0]     res_icnt,
  input logic                 res_good,
  input logic                 res_bad
);
  // R2
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $onehot({res_good, res_bad}));
  // R2
  verdict_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> (!res_good && !res_bad));
  // R2
  pulse_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(in_vld && in_last));
  // R11
  unwalked_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && (res_class == 3'd2 || res_class == 3'd4 || res_class == 3'd5))
      |-> (res_mask == '0 && res_icnt == '0 && res_base == '0));
  // R7
  long_base_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_class == 3'd3) |-> (res_base == IDX_W'(2) && res_mask[1:0] == 2'b00));
  // R6
  short_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_class == 3'd1) |-> (res_addr[13:7] == '0 && res_addr != '0 && !res_mask[0]));
  // R10
  good_has_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_good && res_class <= 3'd1) |-> (res_icnt != '0));
  // R8
  icnt_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ($countones(res_mask) == int'(res_icnt)));
endmodule

bind pkt_classifier pkt_classifier_chk #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_last(in_last), .res_vld(res_vld),
  .res_class(res_class), .res_addr(res_addr), .res_base(res_base), .res_mask(res_mask),
  .res_icnt(res_icnt), .res_good(res_good), .res_bad(res_bad)
);

// File: tb/sim_pkt_classifier.sv
`timescale 1ns/100ps
module sim_pkt_classifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        res_vld, res_good, res_bad;
  logic [2:0]  res_class, res_base, res_icnt;
  logic [13:0] res_addr;
  logic [5:0]  res_mask;

  int checks = 0, fails = 0, cycles = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_classifier u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_last(in_last), .in_data(in_data),
    .res_vld(res_vld), .res_class(res_class), .res_addr(res_addr), .res_base(res_base),
    .res_mask(res_mask), .res_icnt(res_icnt), .res_good(res_good), .res_bad(res_bad)
  );

  typedef struct packed {
    logic [63:0] pay;   // byte k at bits 63-8k downto 56-8k
    logic [3:0]  n;     // total bytes including check byte
    logic        flip;  // corrupt check byte
    logic [2:0]  cls;
    logic [13:0] addr;
    logic [2:0]  base;
    logic [5:0]  mask;
    logic [2:0]  icnt;
    logic        good;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R6 short, one speed byte
    '{ {8'h03,8'h76,48'h0},           4'd3,1'b0,3'd1,14'd3,     3'd1,6'b000010,3'd1,1'b1},
    // R6 broadcast
    '{ {8'h00,8'h60,48'h0},           4'd3,1'b0,3'd0,14'd0,     3'd1,6'b000010,3'd1,1'b1},
    // R7 long + 2-byte advanced op
    '{ {8'hC1,8'h23,8'h3F,8'h85,32'h0},4'd5,1'b0,3'd3,14'h0123,3'd2,6'b000100,3'd1,1'b1},
    // R8 three-byte 1110 opener
    '{ {8'h05,8'hE4,8'h12,8'h34,32'h0},4'd5,1'b0,3'd1,14'd5,   3'd1,6'b000010,3'd1,1'b1},
    // R9 11000000 takes three bytes
    '{ {8'h05,8'hC0,8'h01,8'h02,32'h0},4'd5,1'b0,3'd1,14'd5,   3'd1,6'b000010,3'd1,1'b1},
    // R9 other 110 opener two bytes, then 1-byte op
    '{ {8'h05,8'hDE,8'h55,8'h90,32'h0},4'd5,1'b0,3'd1,14'd5,   3'd1,6'b001010,3'd2,1'b1},
    // R8 0001 opener two bytes
    '{ {8'h07,8'h12,8'h05,40'h0},     4'd4,1'b0,3'd1,14'd7,     3'd1,6'b000010,3'd1,1'b1},
    // R8 1111 opener two bytes
    '{ {8'h07,8'hF2,8'h10,40'h0},     4'd4,1'b0,3'd1,14'd7,     3'd1,6'b000010,3'd1,1'b1},
    // R10 overrun of check byte
    '{ {8'h05,8'hE4,8'h12,40'h0},     4'd4,1'b0,3'd1,14'd5,     3'd1,6'b000010,3'd1,1'b0},
    // R12 accessory
    '{ {8'h81,8'hF9,48'h0},           4'd3,1'b0,3'd2,14'd1,     3'd0,6'b000000,3'd0,1'b1},
    // R11 idle
    '{ {8'hFF,8'h00,48'h0},           4'd3,1'b0,3'd5,14'd0,     3'd0,6'b000000,3'd0,1'b1},
    // R11 reserved
    '{ {8'hE8,8'h00,48'h0},           4'd3,1'b0,3'd4,14'd0,     3'd0,6'b000000,3'd0,1'b1},
    // R5 bad check byte
    '{ {8'h03,8'h76,48'h0},           4'd3,1'b1,3'd1,14'd3,     3'd1,6'b000010,3'd1,1'b0},
    // R4 too short
    '{ {8'h03,56'h0},                 4'd2,1'b0,3'd1,14'd3,     3'd1,6'b000000,3'd0,1'b0},
    // R4 too long
    '{ {8'h03,8'h60,8'h60,8'h60,8'h60,8'h60,8'h60,8'h0},4'd8,1'b0,3'd1,14'd3,3'd1,6'b111110,3'd5,1'b0},
    // R4 six bytes, three ops after long address
    '{ {8'hC0,8'h01,8'h60,8'h60,8'h60,24'h0},4'd6,1'b0,3'd3,14'd1,3'd2,6'b011100,3'd3,1'b1},
    // R10 long with no instruction
    '{ {8'hC0,8'h01,48'h0},           4'd3,1'b0,3'd3,14'd1,     3'd2,6'b000000,3'd0,1'b0},
    // R3 range edges: 0xE7 is long
    '{ {8'hE7,8'hFF,8'h60,40'h0},     4'd4,1'b0,3'd3,14'h27FF,  3'd2,6'b000100,3'd1,1'b1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [63:0] pay, input int n, input logic flip, input int gap);
    logic [7:0] x;
    x = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld  = 1'b1;
      in_last = (k == n - 1);
      if (k == n - 1) in_data = x ^ (flip ? 8'h01 : 8'h00);
      else begin
        in_data = pay[63 - 8*k -: 8];
        x = x ^ in_data;
      end
      if (gap > 0 && k != n - 1) begin
        @(negedge clk);
        in_vld = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_vld = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_vec(input vec_t v);
    check("R2", "res_vld", int'(res_vld), 1);
    check("R3", "class", int'(res_class), int'(v.cls));
    check("R6/R7/R12 addr", "addr", int'(res_addr), int'(v.addr));
    check("R6/R7 base", "base", int'(res_base), int'(v.base));
    check("R8 mask", "mask", int'(res_mask), int'(v.mask));
    check("R8 icnt", "icnt", int'(res_icnt), int'(v.icnt));
    check("R4/R5/R10 good", "good", int'(res_good), int'(v.good));
    check("R2", "bad", int'(res_bad), int'(!v.good));
    @(negedge clk);
    check("R2", "pulse end", int'(res_vld), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "res_vld", int'(res_vld), 0);
    check("R1", "good|bad", int'(res_good | res_bad), 0);
    check("R1", "mask", int'(res_mask), 0);
    check("R1", "icnt", int'(res_icnt), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send_pkt(VECS[i].pay, int'(VECS[i].n), VECS[i].flip, (i % 3 == 1) ? 2 : 0);
      check_vec(VECS[i]);
    end

    // R3 class edges, each a 3-byte packet
    send_pkt({8'h7F,8'h60,48'h0}, 3, 1'b0, 0);
    check("R3 7F", "class", int'(res_class), 1);
    check("R6 7F", "addr", int'(res_addr), 127);
    @(negedge clk);
    send_pkt({8'hBF,8'h80,48'h0}, 3, 1'b0, 0);
    check("R3 BF", "class", int'(res_class), 2);
    check("R12 BF", "addr", int'(res_addr), 63);
    @(negedge clk);
    send_pkt({8'hFE,8'h00,48'h0}, 3, 1'b0, 0);
    check("R3 FE", "class", int'(res_class), 4);
    check("R11 FE", "good", int'(res_good), 1);
    @(negedge clk);

    // R1 reset in the middle of a packet, then a clean one
    @(negedge clk);
    in_vld = 1'b1; in_last = 1'b0; in_data = 8'hC0;
    @(negedge clk);
    in_data = 8'hE4;
    @(negedge clk);
    in_vld = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid", "res_vld", int'(res_vld), 0);
    rst = 1'b0;
    send_pkt({8'h05,8'h60,48'h0}, 3, 1'b0, 0);
    check("R1 after", "class", int'(res_class), 1);
    check("R1 after", "mask", int'(res_mask), 2);
    check("R1 after", "good", int'(res_good), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule